// File: doc/BRIEF.md
# Write-Only Serial Configuration Port

This block is a write-only serial target that lets a host load a bank of configuration registers over three wires: a select line (active low), a bit clock and a data line. All three pins are brought into the system clock domain through synchronisers. The bit clock is oversampled, so it must run well below the system clock. While the select line is low, the port takes one bit from the data line on each rising edge of the bit clock, most significant bit first. A frame opens with an 8-bit header: a 7-bit chip identity and a direction bit. Next comes an 8-bit register pointer, then any number of 8-bit data bytes. Each complete data byte leaves the port as a single-cycle write strobe, together with a register address and a data value. A register file next to the port consumes these strobes. Nothing can be read back.

The select pin is shared with a two-wire bus address input. A mode flag records that the port has moved to the serial-peripheral protocol. The flag is set the first time the select pin is seen going from high to low after reset, and only a reset clears it. A frame can start only on a high-to-low transition of the select pin, and the transition that sets the flag also opens the first frame.

Top module: `spi_cfg_port`

## Requirements
- R1: While reset is high, and in the first cycle after it, `wr_en` is 0 and `spi_mode` is 0.
- R2: `spi_mode` becomes 1 after the first high-to-low transition of `cs_pin_n` that follows reset. It stays 1 through any later select activity and returns to 0 only on reset.
- R3: If `cs_pin_n` is already low when reset ends, neither the mode flag nor a frame starts until the pin has gone high and then low again.
- R4: A frame with header bits 0011000 followed by direction bit 0, then pointer byte P, then data byte D (all MSB first), produces exactly one write with `wr_addr`=P and `wr_data`=D.
- R5: Within one frame, each further data byte is written to the address after the previous one, and the address wraps from 0xFF to 0x00.
- R6: If the seven identity bits differ from 0011000, no write is produced until the select pin rises.
- R7: If the direction bit (the eighth header bit) is 1, no write is produced in that frame.
- R8: A rise of the select pin partway through a data byte discards that byte. The bytes completed earlier in the same frame are still written.
- R9: `wr_en` is high for exactly one system clock cycle per completed data byte.
- R10: After the select pin rises and falls again, the next 16 bits are taken as a new header and pointer. No count of bits carries over from the previous frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_pin_n | input | 1 | Shared select pin, active low, asynchronous |
| sclk_pin | input | 1 | Serial bit clock, data taken on its rising edge |
| sdin_pin | input | 1 | Serial data in, MSB first |
| spi_mode | output | 1 | Serial-peripheral mode flag |
| wr_en | output | 1 | Single-cycle register write strobe |
| wr_addr | output | 8 | Register address for the write |
| wr_data | output | 8 | Register data for the write |

## Verification
The bench sends a one-byte frame and a three-byte burst that starts at 0xFE. Together these separate a correct pointer step and wrap from a pointer that stays put or saturates. Frames with a wrong identity and with the direction bit set must produce no strobes, which shows that the header is actually checked rather than just counted. A frame cut off five bits into its second byte, followed by a fresh frame, shows both that partial bytes are discarded and that the bit count restarts with each frame. A select pin held low out of reset, and a reset given after frames have run, test the two ends of the mode flag's lifetime.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  typedef enum logic [2:0] {
    FR_IDLE,
    FR_HEAD,
    FR_PTR,
    FR_DATA,
    FR_SKIP
  } frame_st_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_sync
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], pin_in[g]};
    end
    assign pin_sync[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/spi_mode_latch.sv
module spi_mode_latch (
  input  logic clk,
  input  logic rst,
  input  logic sel_n_s,
  output logic sel_fall,
  output logic mode_q
);
  logic sel_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_prev <= 1'b0;
      mode_q   <= 1'b0;
    end else begin
      sel_prev <= sel_n_s;
      if (sel_fall) mode_q <= 1'b1;
    end
  end

  // a fall needs a high level observed after reset
  assign sel_fall = sel_prev & ~sel_n_s;
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_cfg_pkg::*;
#(
  parameter int         BYTE_W  = 8,
  parameter int         ID_W    = 7,
  parameter logic [6:0] CHIP_ID = 7'b0011000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n_s,
  input  logic              sel_fall,
  input  logic              sclk_s,
  input  logic              din_s,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              in_skip
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  frame_st_e         state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] ptr;
  logic              sclk_prev;
  logic              sclk_rise;
  logic [BYTE_W-1:0] byte_now;
  logic              shifting;
  logic              head_ok;

  assign sclk_rise = sclk_s & ~sclk_prev;
  assign byte_now  = {shreg[BYTE_W-2:0], din_s};
  assign shifting  = (state == FR_HEAD) || (state == FR_PTR) || (state == FR_DATA);
  assign head_ok   = (byte_now[BYTE_W-1 -: ID_W] == CHIP_ID) && !byte_now[0];
  assign in_skip   = (state == FR_SKIP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= FR_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      ptr       <= '0;
      sclk_prev <= 1'b0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      sclk_prev <= sclk_s;
      wr_en     <= 1'b0;
      if (sel_n_s) begin
        state   <= FR_IDLE;
        bit_cnt <= '0;
      end else if (sel_fall) begin
        state   <= FR_HEAD;
        bit_cnt <= '0;
      end else if (sclk_rise && shifting) begin
        shreg   <= byte_now;
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == LAST_BIT) begin
          bit_cnt <= '0;
          unique case (state)
            FR_HEAD: state <= head_ok ? FR_PTR : FR_SKIP;
            FR_PTR: begin
              ptr   <= byte_now;
              state <= FR_DATA;
            end
            FR_DATA: begin
              wr_en   <= 1'b1;
              wr_addr <= ptr;
              wr_data <= byte_now;
              ptr     <= ptr + 1'b1;
            end
            default: state <= state;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port #(
  parameter int         SYNC_STAGES = 2,
  parameter int         BYTE_W      = 8,
  parameter int         ID_W        = 7,
  parameter logic [6:0] CHIP_ID     = 7'b0011000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_pin_n,
  input  logic              sclk_pin,
  input  logic              sdin_pin,
  output logic              spi_mode,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  localparam int NPINS = 3;

  logic [NPINS-1:0] pins_s;
  logic             sel_fall;
  logic             frame_skip;

  spi_pin_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .pin_in  ({cs_pin_n, sclk_pin, sdin_pin}),
    .pin_sync(pins_s)
  );

  spi_mode_latch u_mode (
    .clk     (clk),
    .rst     (rst),
    .sel_n_s (pins_s[2]),
    .sel_fall(sel_fall),
    .mode_q  (spi_mode)
  );

  spi_frame_rx #(.BYTE_W(BYTE_W), .ID_W(ID_W), .CHIP_ID(CHIP_ID)) u_frame (
    .clk     (clk),
    .rst     (rst),
    .sel_n_s (pins_s[2]),
    .sel_fall(sel_fall),
    .sclk_s  (pins_s[1]),
    .din_s   (pins_s[0]),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .in_skip (frame_skip)
  );
endmodule

// File: rtl/spi_cfg_port_chk.sv
module spi_cfg_port_chk (
  input logic clk,
  input logic rst,
  input logic spi_mode,
  input logic wr_en,
  input logic skip_st
);
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (!wr_en && !spi_mode));
  p_mode_sticky_r2: assert property (@(posedge clk) disable iff (rst) spi_mode |=> spi_mode);
  p_write_needs_mode_r4: assert property (@(posedge clk) disable iff (rst) wr_en |-> spi_mode);
  p_no_write_skip_r6: assert property (@(posedge clk) disable iff (rst) skip_st |-> !wr_en);
  p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst) wr_en |=> !wr_en);
endmodule

bind spi_cfg_port spi_cfg_port_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .spi_mode(spi_mode),
  .wr_en   (wr_en),
  .skip_st (frame_skip)
);

// File: tb/test_spi_cfg_port.sv
module test_spi_cfg_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_pin_n = 1'b0;
  logic sclk_pin = 1'b0;
  logic sdin_pin = 1'b0;
  logic spi_mode, wr_en;
  logic [7:0] wr_addr, wr_data;

  int checks = 0;
  int fails  = 0;
  int cap_n  = 0;
  logic [7:0] cap_addr [64];
  logic [7:0] cap_data [64];
  logic [7:0] tx [8];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cfg_port i_spi_cfg_port (
    .clk(clk), .rst(rst), .cs_pin_n(cs_pin_n), .sclk_pin(sclk_pin),
    .sdin_pin(sdin_pin), .spi_mode(spi_mode), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always @(negedge clk) begin
    if (wr_en && cap_n < 64) begin
      cap_addr[cap_n] = wr_addr;
      cap_data[cap_n] = wr_data;
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdin_pin = b;
    cyc(HALF_BIT);
    sclk_pin = 1'b1;
    cyc(HALF_BIT);
    sclk_pin = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic frame(input logic [6:0] id, input logic rw, input logic [7:0] ptr,
                       input int nfull, input int part_bits);
    cap_n = 0;
    cs_pin_n = 1'b0;
    cyc(HALF_BIT);
    send_byte({id, rw});
    send_byte(ptr);
    for (int k = 0; k < nfull; k++) send_byte(tx[k]);
    for (int j = 0; j < part_bits; j++) send_bit(tx[nfull][7-j]);
    cyc(HALF_BIT);
    cs_pin_n = 1'b1;
    cyc(12);
  endtask

  task automatic t_reset();
    cyc(3);
    chk(wr_en == 1'b0, "R1", "wr_en in reset", wr_en, 0);
    chk(spi_mode == 1'b0, "R1", "spi_mode in reset", spi_mode, 0);
    rst = 1'b0;
    cyc(1);
    chk(wr_en == 1'b0 && spi_mode == 1'b0, "R1", "outputs after reset", {wr_en, spi_mode}, 0);
  endtask

  task automatic t_low_at_start();
    cap_n = 0;
    cyc(10);
    chk(spi_mode == 1'b0, "R3", "mode with select low from reset", spi_mode, 0);
    send_byte(8'h30);
    send_byte(8'h01);
    send_byte(8'hEE);
    cyc(8);
    chk(cap_n == 0, "R3", "writes before first fall", cap_n, 0);
    cs_pin_n = 1'b1;
    cyc(8);
    chk(spi_mode == 1'b0, "R2", "mode after rise only", spi_mode, 0);
    cs_pin_n = 1'b0;
    cyc(8);
    chk(spi_mode == 1'b1, "R2", "mode after first fall", spi_mode, 1);
    cs_pin_n = 1'b1;
    cyc(8);
  endtask

  task automatic t_single();
    tx[0] = 8'hA5;
    frame(7'b0011000, 1'b0, 8'h12, 1, 0);
    chk(cap_n == 1, "R9", "strobe cycles for one byte", cap_n, 1);
    chk(cap_addr[0] == 8'h12, "R4", "single addr", cap_addr[0], 8'h12);
    chk(cap_data[0] == 8'hA5, "R4", "single data", cap_data[0], 8'hA5);
  endtask

  task automatic t_burst();
    tx[0] = 8'h11; tx[1] = 8'h22; tx[2] = 8'h33;
    frame(7'b0011000, 1'b0, 8'hFE, 3, 0);
    chk(cap_n == 3, "R5", "burst write count", cap_n, 3);
    chk(cap_addr[0] == 8'hFE && cap_data[0] == 8'h11, "R5", "burst byte0", {cap_addr[0], cap_data[0]}, 16'hFE11);
    chk(cap_addr[1] == 8'hFF && cap_data[1] == 8'h22, "R5", "burst byte1", {cap_addr[1], cap_data[1]}, 16'hFF22);
    chk(cap_addr[2] == 8'h00 && cap_data[2] == 8'h33, "R5", "burst wrap", {cap_addr[2], cap_data[2]}, 16'h0033);
  endtask

  task automatic t_bad_id();
    tx[0] = 8'h5C; tx[1] = 8'h30;
    frame(7'b0011001, 1'b0, 8'h30, 2, 0);
    chk(cap_n == 0, "R6", "writes with wrong identity", cap_n, 0);
  endtask

  task automatic t_read_dir();
    tx[0] = 8'h77;
    frame(7'b0011000, 1'b1, 8'h05, 1, 0);
    chk(cap_n == 0, "R7", "writes with direction bit high", cap_n, 0);
  endtask

  task automatic t_partial_and_restart();
    tx[0] = 8'h5A; tx[1] = 8'hFF;
    frame(7'b0011000, 1'b0, 8'h40, 1, 5);
    chk(cap_n == 1, "R8", "writes with cut byte", cap_n, 1);
    chk(cap_addr[0] == 8'h40 && cap_data[0] == 8'h5A, "R8", "completed byte kept", {cap_addr[0], cap_data[0]}, 16'h405A);
    tx[0] = 8'h0F;
    frame(7'b0011000, 1'b0, 8'h70, 1, 0);
    chk(cap_n == 1, "R10", "writes in fresh frame", cap_n, 1);
    chk(cap_addr[0] == 8'h70 && cap_data[0] == 8'h0F, "R10", "fresh frame alignment", {cap_addr[0], cap_data[0]}, 16'h700F);
  endtask

  task automatic t_mode_lifetime();
    chk(spi_mode == 1'b1, "R2", "mode kept after frames", spi_mode, 1);
    rst = 1'b1;
    cyc(3);
    rst = 1'b0;
    cyc(1);
    chk(spi_mode == 1'b0, "R2", "mode cleared by reset", spi_mode, 0);
  endtask

  initial begin
    t_reset();
    t_low_at_start();
    t_single();
    t_burst();
    t_bad_id();
    t_read_dir();
    t_partial_and_restart();
    t_mode_lifetime();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule